// File: doc/BRIEF.md
# Quick DMA channel trigger controller

This block sits beside a DMA transfer engine and decides when each of eight quick channels asks for a transfer. Software binds each channel to one parameter slot and to one word inside that slot. It does this through a per-channel map register. Software then arms the channel with an enable bit. From that point, the block watches the shared write port. When a write lands on the bound word of an armed channel's slot, the block raises a transfer request that carries the channel number and the slot number. Software needs no separate start command: writing the last parameter word is the start.

A raised trigger is held in a per-channel secondary-event bit until the engine takes the request. A small two-state arbiter offers the held requests to the engine one at a time, lowest channel first. A second trigger on a channel whose request is still held is not queued. It is recorded in a missed-event bit. The engine reports finished transfers with a 6-bit completion code. Each code sets one of 64 pending bits, split into a low half and a high half. Software clears pending, missed and secondary bits by writing ones.

The arbiter has two states. ARB_IDLE moves to ARB_OFFER when any secondary bit is set; this transition is named *select*. ARB_OFFER moves back to ARB_IDLE when the engine accepts; this transition is named *accept*.

Top module: `qdma_trig_ctrl`

## Requirements
- R1: A write to byte address 0x200+4*c loads channel c's map. Bits 13:5 of the data give the slot and bits 4:2 give the trigger word; all other data bits are ignored. For an armed channel, a write to address 0x4000+32*slot+4*word (slot region 0x4000 to 0x7FFF) produces exactly one request with req_chan=c and req_slot=slot.
- R2: Writing ones to 0x108C arms the channels whose data bits [7:0] are one, and writing ones to 0x1088 disarms them; enable_mask shows the arm bits. A trigger-word write to a disarmed channel sets no secondary bit and produces no request.
- R3: Writes in the slot region that hit a different word of the mapped slot, or a different slot, set nothing and produce no request.
- R4: A trigger sets the channel's secondary bit. While req_valid is high and req_ready is low, req_valid, req_chan and req_slot hold. Acceptance (req_valid and req_ready high at a clock edge) clears the accepted channel's secondary bit.
- R5: A trigger on a channel whose secondary bit is already set sets its missed bit and produces no further request.
- R6: Writing ones to 0x314 clears missed bits, and writing ones to 0x1094 clears secondary bits, one data bit per channel.
- R7: When several secondary bits are pending at selection, the lowest-numbered channel is offered first.
- R8: A completion with code k below 32 sets pend_lo[k]; a code k of 32 or more sets pend_hi[k-32].
- R9: Writing ones to 0x1070 clears pend_lo bits and writing ones to 0x1074 clears pend_hi bits. A completion in the same cycle as a clear of the same bit leaves the bit set.
- R10: After reset all masks, pending bits and maps are zero and req_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for registers and parameter slots |
| wr_addr | input | 16 | Byte address of the write |
| wr_data | input | 32 | Write data |
| cmpl_valid | input | 1 | Completion report strobe from the engine |
| cmpl_code | input | 6 | Completion code |
| req_ready | input | 1 | Engine takes the offered request |
| req_valid | output | 1 | A request is offered |
| req_chan | output | 3 | Channel of the offered request |
| req_slot | output | 9 | Slot of the offered request |
| enable_mask | output | 8 | Arm bits per channel |
| secondary_mask | output | 8 | Held-trigger bits per channel |
| missed_mask | output | 8 | Missed-trigger bits per channel |
| pend_lo | output | 32 | Pending bits for codes 0 to 31 |
| pend_hi | output | 32 | Pending bits for codes 32 to 63 |

## Verification
The missed-event path is the hardest case to reach from the ports. It needs a second trigger while the first one is still held. With an engine that is always ready, the held bit lives only two cycles. The stimulus therefore holds req_ready low, triggers the same channel twice, and checks the missed bit and the frozen offer. Only then does it release the engine, and the scoreboard expects exactly one request. Ordering is reached the same way: one slot write hits two channels bound to the same word, and the scoreboard expects the lower channel before the higher one.

// File: rtl/qtc_pkg.sv
package qtc_pkg;
    localparam int ADDR_W = 16;
    localparam logic [ADDR_W-1:0] MAP_BASE     = 16'h0200;
    localparam logic [ADDR_W-1:0] MISS_CLR     = 16'h0314;
    localparam logic [ADDR_W-1:0] PEND_CLR_LO  = 16'h1070;
    localparam logic [ADDR_W-1:0] PEND_CLR_HI  = 16'h1074;
    localparam logic [ADDR_W-1:0] EN_CLR       = 16'h1088;
    localparam logic [ADDR_W-1:0] EN_SET       = 16'h108C;
    localparam logic [ADDR_W-1:0] SEC_CLR      = 16'h1094;
    localparam logic [ADDR_W-1:0] SLOT_BASE    = 16'h4000;
    localparam int WORD_W = 3;

    typedef enum logic [0:0] {
        ARB_IDLE  = 1'b0,
        ARB_OFFER = 1'b1
    } arb_state_t;
endpackage

// File: rtl/qtc_regfile.sv
module qtc_regfile
    import qtc_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int SLOT_W = 9,
    parameter int DATA_W = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [DATA_W-1:0]                  wr_data,
    output logic [NUM_CH-1:0][SLOT_W-1:0]      map_slot,
    output logic [NUM_CH-1:0][WORD_W-1:0]      map_word,
    output logic [NUM_CH-1:0]                  enable,
    output logic [NUM_CH-1:0]                  sec_clr,
    output logic [NUM_CH-1:0]                  miss_clr,
    output logic [DATA_W-1:0]                  pend_clr_lo,
    output logic [DATA_W-1:0]                  pend_clr_hi,
    output logic                               slot_wr,
    output logic [SLOT_W-1:0]                  wr_slot,
    output logic [WORD_W-1:0]                  wr_word
);
    localparam int REGION_SH = SLOT_W + 5;

    logic [NUM_CH-1:0] map_hit;
    logic [NUM_CH-1:0] en_set_v;
    logic [NUM_CH-1:0] en_clr_v;

    // decode of the single-bit-per-channel clear and arm registers
    always_comb begin
        en_set_v    = (wr_en && wr_addr == EN_SET)   ? wr_data[NUM_CH-1:0] : '0;
        en_clr_v    = (wr_en && wr_addr == EN_CLR)   ? wr_data[NUM_CH-1:0] : '0;
        sec_clr     = (wr_en && wr_addr == SEC_CLR)  ? wr_data[NUM_CH-1:0] : '0;
        miss_clr    = (wr_en && wr_addr == MISS_CLR) ? wr_data[NUM_CH-1:0] : '0;
        pend_clr_lo = (wr_en && wr_addr == PEND_CLR_LO) ? wr_data : '0;
        pend_clr_hi = (wr_en && wr_addr == PEND_CLR_HI) ? wr_data : '0;
        slot_wr     = wr_en && ((wr_addr >> REGION_SH) == (SLOT_BASE >> REGION_SH));
        wr_slot     = wr_addr[SLOT_W+4:5];
        wr_word     = wr_addr[4:2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) enable <= '0;
        else        enable <= (enable | en_set_v) & ~en_clr_v;
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_map
            assign map_hit[c] = wr_en && (wr_addr == MAP_BASE + ADDR_W'(4 * c));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    map_slot[c] <= '0;
                    map_word[c] <= '0;
                end else if (map_hit[c]) begin
                    map_slot[c] <= wr_data[SLOT_W+4:5];
                    map_word[c] <= wr_data[4:2];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/qtc_event.sv
module qtc_event
    import qtc_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int SLOT_W = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          slot_wr,
    input  logic [SLOT_W-1:0]             wr_slot,
    input  logic [WORD_W-1:0]             wr_word,
    input  logic [NUM_CH-1:0][SLOT_W-1:0] map_slot,
    input  logic [NUM_CH-1:0][WORD_W-1:0] map_word,
    input  logic [NUM_CH-1:0]             enable,
    input  logic [NUM_CH-1:0]             sec_clr,
    input  logic [NUM_CH-1:0]             miss_clr,
    input  logic [NUM_CH-1:0]             accept_vec,
    output logic [NUM_CH-1:0]             sec_q,
    output logic [NUM_CH-1:0]             miss_q
);
    logic [NUM_CH-1:0] trig;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_trig
            assign trig[c] = slot_wr && enable[c] &&
                             (wr_slot == map_slot[c]) && (wr_word == map_word[c]);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q  <= '0;
            miss_q <= '0;
        end else begin
            // a trigger on a held channel becomes a miss, not a new request
            sec_q  <= (sec_q & ~accept_vec & ~sec_clr) | (trig & ~sec_q);
            miss_q <= (miss_q & ~miss_clr) | (trig & sec_q);
        end
    end
endmodule

// File: rtl/qtc_arb.sv
module qtc_arb
    import qtc_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int SLOT_W = 9,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CH-1:0]             sec_vec,
    input  logic [NUM_CH-1:0][SLOT_W-1:0] map_slot,
    input  logic                          req_ready,
    output logic                          req_valid,
    output logic [CH_W-1:0]               req_chan,
    output logic [SLOT_W-1:0]             req_slot,
    output logic [NUM_CH-1:0]             accept_vec
);
    arb_state_t        state_q, state_d;
    logic [CH_W-1:0]   pick_idx;
    logic [CH_W-1:0]   chan_q;
    logic [SLOT_W-1:0] slot_q;

    // lowest set channel wins
    always_comb begin
        pick_idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (sec_vec[i]) pick_idx = CH_W'(i);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:  if (|sec_vec)  state_d = ARB_OFFER;  // select
            ARB_OFFER: if (req_ready) state_d = ARB_IDLE;   // accept
            default:                  state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            chan_q  <= '0;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ARB_IDLE && |sec_vec) begin
                chan_q <= pick_idx;
                slot_q <= map_slot[pick_idx];
            end
        end
    end

    always_comb begin
        req_valid  = 1'b0;
        accept_vec = '0;
        unique case (state_q)
            ARB_IDLE: ;
            ARB_OFFER: begin
                req_valid = 1'b1;
                if (req_ready) accept_vec[chan_q] = 1'b1;
            end
            default: ;
        endcase
        req_chan = chan_q;
        req_slot = slot_q;
    end
endmodule

// File: rtl/qtc_pend.sv
module qtc_pend #(
    parameter int CODE_W = 6,
    localparam int HALF_W = 2 ** (CODE_W - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmpl_valid,
    input  logic [CODE_W-1:0] cmpl_code,
    input  logic [HALF_W-1:0] clr_lo,
    input  logic [HALF_W-1:0] clr_hi,
    output logic [HALF_W-1:0] pend_lo,
    output logic [HALF_W-1:0] pend_hi
);
    logic [2*HALF_W-1:0] set_v;
    logic [2*HALF_W-1:0] pend_q;

    always_comb begin
        set_v = '0;
        if (cmpl_valid) set_v[cmpl_code] = 1'b1;
    end

    // set has priority over a clear of the same bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~{clr_hi, clr_lo}) | set_v;
    end

    assign pend_lo = pend_q[HALF_W-1:0];
    assign pend_hi = pend_q[2*HALF_W-1:HALF_W];
endmodule

// File: rtl/qdma_trig_ctrl.sv
module qdma_trig_ctrl
    import qtc_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int SLOT_W = 9,
    parameter int CODE_W = 6,
    parameter int DATA_W = 32,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cmpl_valid,
    input  logic [CODE_W-1:0] cmpl_code,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [CH_W-1:0]   req_chan,
    output logic [SLOT_W-1:0] req_slot,
    output logic [NUM_CH-1:0] enable_mask,
    output logic [NUM_CH-1:0] secondary_mask,
    output logic [NUM_CH-1:0] missed_mask,
    output logic [DATA_W-1:0] pend_lo,
    output logic [DATA_W-1:0] pend_hi
);
    logic [NUM_CH-1:0][SLOT_W-1:0] map_slot;
    logic [NUM_CH-1:0][WORD_W-1:0] map_word;
    logic [NUM_CH-1:0]             sec_clr, miss_clr, accept_vec;
    logic [DATA_W-1:0]             pend_clr_lo, pend_clr_hi;
    logic                          slot_wr;
    logic [SLOT_W-1:0]             wr_slot;
    logic [WORD_W-1:0]             wr_word;

    qtc_regfile #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .map_slot(map_slot), .map_word(map_word), .enable(enable_mask),
        .sec_clr(sec_clr), .miss_clr(miss_clr),
        .pend_clr_lo(pend_clr_lo), .pend_clr_hi(pend_clr_hi),
        .slot_wr(slot_wr), .wr_slot(wr_slot), .wr_word(wr_word)
    );

    qtc_event #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_event (
        .clk(clk), .rst_n(rst_n), .slot_wr(slot_wr), .wr_slot(wr_slot), .wr_word(wr_word),
        .map_slot(map_slot), .map_word(map_word), .enable(enable_mask),
        .sec_clr(sec_clr), .miss_clr(miss_clr), .accept_vec(accept_vec),
        .sec_q(secondary_mask), .miss_q(missed_mask)
    );

    qtc_arb #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .sec_vec(secondary_mask), .map_slot(map_slot),
        .req_ready(req_ready), .req_valid(req_valid), .req_chan(req_chan),
        .req_slot(req_slot), .accept_vec(accept_vec)
    );

    qtc_pend #(.CODE_W(CODE_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .cmpl_valid(cmpl_valid), .cmpl_code(cmpl_code),
        .clr_lo(pend_clr_lo), .clr_hi(pend_clr_hi), .pend_lo(pend_lo), .pend_hi(pend_hi)
    );
endmodule

// File: rtl/qtc_checks.sv
module qtc_checks #(
    parameter int NUM_CH = 8,
    parameter int SLOT_W = 9,
    parameter int CODE_W = 6,
    parameter int DATA_W = 32,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmpl_valid,
    input logic [CODE_W-1:0] cmpl_code,
    input logic              req_ready,
    input logic              req_valid,
    input logic [CH_W-1:0]   req_chan,
    input logic [SLOT_W-1:0] req_slot,
    input logic [NUM_CH-1:0] enable_mask,
    input logic [NUM_CH-1:0] secondary_mask,
    input logic [NUM_CH-1:0] missed_mask,
    input logic [DATA_W-1:0] pend_lo,
    input logic [DATA_W-1:0] pend_hi
);
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_chan) && $stable(req_slot));

    assert_offer_from_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(|secondary_mask));

    assert_lowest_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |->
            (($past(secondary_mask) & ((NUM_CH'(1) << req_chan) - NUM_CH'(1))) == '0));

    assert_pend_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid && !cmpl_code[CODE_W-1] |=> pend_lo[$past(cmpl_code[CODE_W-2:0])]);

    assert_pend_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid && cmpl_code[CODE_W-1] |=> pend_hi[$past(cmpl_code[CODE_W-2:0])]);

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            assert_armed_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(secondary_mask[c]) |-> $past(enable_mask[c]));
            assert_miss_when_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(missed_mask[c]) |-> $past(secondary_mask[c]));
        end
    endgenerate
endmodule

bind qdma_trig_ctrl qtc_checks #(
    .NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .CODE_W(CODE_W), .DATA_W(DATA_W)
) u_checks (
    .clk(clk), .rst_n(rst_n), .cmpl_valid(cmpl_valid), .cmpl_code(cmpl_code),
    .req_ready(req_ready), .req_valid(req_valid), .req_chan(req_chan), .req_slot(req_slot),
    .enable_mask(enable_mask), .secondary_mask(secondary_mask), .missed_mask(missed_mask),
    .pend_lo(pend_lo), .pend_hi(pend_hi)
);

// File: tb/qdma_trig_ctrl_tb.sv
`timescale 1ns/1ps
module qdma_trig_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        cmpl_valid = 1'b0;
    logic [5:0]  cmpl_code = '0;
    logic        req_ready = 1'b1;
    logic        req_valid;
    logic [2:0]  req_chan;
    logic [8:0]  req_slot;
    logic [7:0]  enable_mask, secondary_mask, missed_mask;
    logic [31:0] pend_lo, pend_hi;

    int errors = 0;
    int checks = 0;
    logic [11:0] exp_q[$];

    always #2 clk = ~clk;

    qdma_trig_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmpl_valid(cmpl_valid), .cmpl_code(cmpl_code), .req_ready(req_ready),
        .req_valid(req_valid), .req_chan(req_chan), .req_slot(req_slot),
        .enable_mask(enable_mask), .secondary_mask(secondary_mask),
        .missed_mask(missed_mask), .pend_lo(pend_lo), .pend_hi(pend_hi)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic map_ch(input int c, input int slot, input int word, input logic [31:0] junk);
        wr(16'h0200 + 16'(4 * c), (32'(slot) << 5) | (32'(word) << 2) | junk);
    endtask

    function automatic logic [15:0] slot_addr(input int slot, input int word);
        return 16'h4000 + 16'(slot * 32) + 16'(word * 4);
    endfunction

    task automatic cmpl(input logic [5:0] code);
        cmpl_valid = 1'b1; cmpl_code = code;
        step();
        cmpl_valid = 1'b0;
    endtask

    // monitor: every accepted request is compared with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && req_valid && req_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1/R3 unexpected request", {52'd0, req_chan, req_slot}, 64'd0);
            end else begin
                logic [11:0] e;
                e = exp_q.pop_front();
                chk({req_chan, req_slot} == e, "R1/R7 request chan/slot",
                    {52'd0, req_chan, req_slot}, {52'd0, e});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(3);
        // R10 reset state
        chk(req_valid == 1'b0, "R10 req_valid", req_valid, 0);
        chk(enable_mask == 0 && secondary_mask == 0 && missed_mask == 0, "R10 masks",
            {enable_mask, secondary_mask, missed_mask}, 0);
        chk(pend_lo == 0 && pend_hi == 0, "R10 pending", {pend_hi, pend_lo}, 0);
        rst_n = 1'b1;
        step(2);

        // R1 basic trigger with junk bits in the map word
        map_ch(0, 5, 2, 32'h8000_0003);
        wr(16'h108C, 32'h01);
        chk(enable_mask == 8'h01, "R2 arm ch0", enable_mask, 8'h01);
        // R3 wrong word and wrong slot are ignored
        wr(slot_addr(5, 1), 32'h0);
        wr(slot_addr(6, 2), 32'h0);
        step(3);
        chk(secondary_mask == 0 && req_valid == 0, "R3 non-trigger writes",
            {secondary_mask, 7'd0, req_valid}, 0);
        exp_q.push_back({3'd0, 9'd5});
        wr(slot_addr(5, 2), 32'hABCD);
        step(5);
        chk(exp_q.size() == 0, "R1 request delivered", exp_q.size(), 0);

        // R1 boundary: highest slot, last word, channel 7
        map_ch(7, 511, 7, 32'h0);
        wr(16'h108C, 32'h80);
        exp_q.push_back({3'd7, 9'd511});
        wr(slot_addr(511, 7), 32'h1);
        step(5);
        chk(exp_q.size() == 0, "R1 top slot delivered", exp_q.size(), 0);

        // R2 disarmed channel ignored, disarm clears bit
        map_ch(4, 48, 0, 32'h0);
        wr(slot_addr(48, 0), 32'h0);
        step(3);
        chk(secondary_mask == 0 && req_valid == 0, "R2 disarmed trigger", secondary_mask, 0);
        wr(16'h108C, 32'h10);
        wr(16'h1088, 32'h10);
        chk(enable_mask == 8'h81, "R2 disarm ch4", enable_mask, 8'h81);
        wr(slot_addr(48, 0), 32'h0);
        step(3);
        chk(secondary_mask == 0, "R2 trigger after disarm", secondary_mask, 0);

        // R4/R5 held offer and missed trigger
        req_ready = 1'b0;
        map_ch(3, 16, 7, 32'h0);
        wr(16'h108C, 32'h08);
        exp_q.push_back({3'd3, 9'd16});
        wr(slot_addr(16, 7), 32'h0);
        chk(secondary_mask == 8'h08, "R4 secondary set", secondary_mask, 8'h08);
        wr(slot_addr(16, 7), 32'h0);
        chk(missed_mask == 8'h08, "R5 missed set", missed_mask, 8'h08);
        step(3);
        chk(req_valid && req_chan == 3 && req_slot == 16, "R4 offer held",
            {req_valid, req_chan, req_slot}, {1'b1, 3'd3, 9'd16});
        req_ready = 1'b1;
        step(4);
        chk(secondary_mask == 0 && exp_q.size() == 0, "R4/R5 single request",
            {secondary_mask, 8'(exp_q.size())}, 0);
        wr(16'h0314, 32'h08);
        chk(missed_mask == 0, "R6 missed clear", missed_mask, 0);

        // R6 secondary clear
        req_ready = 1'b0;
        exp_q.push_back({3'd3, 9'd16});
        wr(slot_addr(16, 7), 32'h0);
        wr(16'h1094, 32'h08);
        chk(secondary_mask == 0, "R6 secondary clear", secondary_mask, 0);
        req_ready = 1'b1;
        step(4);

        // R7 two channels on one slot word: lower first
        req_ready = 1'b0;
        map_ch(1, 32, 3, 32'h0);
        map_ch(6, 32, 3, 32'h0);
        wr(16'h108C, 32'h42);
        exp_q.push_back({3'd1, 9'd32});
        exp_q.push_back({3'd6, 9'd32});
        wr(slot_addr(32, 3), 32'h0);
        step(2);
        chk(req_valid && req_chan == 1, "R7 lowest offered", req_chan, 1);
        req_ready = 1'b1;
        step(6);
        chk(exp_q.size() == 0 && secondary_mask == 0, "R7 both delivered", exp_q.size(), 0);

        // R8 completion codes at both halves and their edges
        cmpl(6'd0);
        cmpl(6'd31);
        cmpl(6'd32);
        cmpl(6'd63);
        chk(pend_lo == 32'h8000_0001, "R8 low half", pend_lo, 32'h8000_0001);
        chk(pend_hi == 32'h8000_0001, "R8 high half", pend_hi, 32'h8000_0001);

        // R9 clears and set-over-clear
        wr(16'h1070, 32'h8000_0000);
        wr(16'h1074, 32'h0000_0001);
        chk(pend_lo == 32'h1 && pend_hi == 32'h8000_0000, "R9 clear",
            {pend_hi, pend_lo}, {32'h8000_0000, 32'h1});
        cmpl_valid = 1'b1; cmpl_code = 6'd5;
        wr_en = 1'b1; wr_addr = 16'h1070; wr_data = 32'h20;
        step();
        cmpl_valid = 1'b0; wr_en = 1'b0;
        chk(pend_lo == 32'h21, "R9 set wins", pend_lo, 32'h21);

        step(3);
        chk(exp_q.size() == 0, "R1 scoreboard empty", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule